// File: doc/BRIEF.md
# Disk Controller Command Intake Handshake

This block collects a command for a floppy-style disk controller, one byte at a time, before execution starts. It drives two handshake status bits for the host. `ready_o` says the block can take a byte now. `dir_o` says which way the next byte moves: 0 means host to block, 1 means block to host. The host writes an opcode byte first. The block then requests each parameter byte in turn. After every accepted byte it lowers `ready_o` until the processing side pulses `byte_done`. Only then does it ask for the next byte.

The number of parameter bytes comes from a small table indexed by the opcode. When the last byte has been processed, the block emits a one-cycle `cmd_valid_o` pulse. It then holds the opcode, the parameter bytes and the count steady until the execution side pulses `exec_done`. An opcode that is not in the table ends collection after the first byte. In that case the block offers a single status byte for the host to read, and then returns to idle.

A host write that arrives while the block is not asking for one is dropped, and a sticky overrun flag is set. The data FIFO is held disabled through the whole command phase, so a bad opcode is seen before any further bytes are taken.

Top module: `disk_cmd_intake`

## Requirements
- R1: After reset, `ready_o`=1, `dir_o`=0, `fifo_block_o`=1, `overrun_o`=0, `invalid_o`=0 and `cmd_valid_o`=0.
- R2: A write (`wr_stb`=1 at a clock edge) is accepted only when `ready_o`=1 and `dir_o`=0.
- R3: From the cycle after an accepted write, `ready_o` is 0. It stays 0 until a `byte_done` pulse arrives.
- R4: When `byte_done` follows a byte and more parameter bytes are still due, `ready_o`=1 and `dir_o`=0 from the next cycle on.
- R5: When `byte_done` follows the final byte of a valid command, `cmd_valid_o` is 1 for exactly the next cycle. After that, `ready_o` stays 0 until an `exec_done` pulse, which returns the block to the idle state of R1.
- R6: `fifo_block_o` is 1 in every state except execution, which is the state between the `cmd_valid_o` pulse and `exec_done`.
- R7: During execution, `cmd_op_o` holds the full opcode byte and `param_count_o` holds the table length. Parameter byte k, counting from 0 in arrival order, sits at `params_o[8k+7:8k]`.
- R8: An opcode not in the table makes the block show `invalid_o`=1, `ready_o`=1, `dir_o`=1 and `result_o`=8'h80, starting the cycle after that opcode's `byte_done`. A `rd_stb` pulse then returns the block to idle with `invalid_o`=0.
- R9: The table is indexed by opcode bits [4:0], and bits [7:5] are ignored. Lengths are: 5'h03→2, 5'h04→1, 5'h05→8, 5'h06→8, 5'h07→1, 5'h08→0, 5'h0A→1, 5'h0D→5, 5'h0F→2, 5'h13→3. Every other code is invalid.
- R10: A write that is not accepted stores nothing and leaves the state unchanged. From the next cycle, `overrun_o`=1, and it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| byte_done | input | 1 | Pulse: the last received byte has been processed |
| rd_stb | input | 1 | Host read strobe for the status byte |
| exec_done | input | 1 | Pulse from execution: hand back to idle |
| ready_o | output | 1 | Block can transfer a byte now |
| dir_o | output | 1 | Transfer direction, 1 = block to host |
| fifo_block_o | output | 1 | Data FIFO held disabled |
| overrun_o | output | 1 | Sticky: a write arrived when not requested |
| invalid_o | output | 1 | Opcode was not recognised |
| result_o | output | 8 | Status byte offered to the host |
| cmd_valid_o | output | 1 | One-cycle pulse: command complete |
| cmd_op_o | output | 8 | Captured opcode |
| param_count_o | output | 4 | Parameter byte count of the opcode |
| params_o | output | 64 | Parameter bytes, byte k at bits 8k+7:8k |

## Verification
The state register is the only register between a strobe and the handshake bits. As a result, `ready_o`, `dir_o`, `invalid_o`, `result_o` and `fifo_block_o` change in the cycle right after the edge that takes `wr_stb`, `byte_done`, `rd_stb` or `exec_done`. `cmd_valid_o` and `overrun_o` come from their own registers and appear in that same next cycle. `cmd_valid_o` drops one cycle later. Each bench task holds its strobe high for one cycle from a falling edge and checks at the following falling edge, so each sample is taken exactly one register stage after the stimulus edge. The one-cycle pulse is checked again at the falling edge after that.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;

  localparam int MAX_PARAMS = 8;
  localparam int LEN_W      = $clog2(MAX_PARAMS + 1);

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_OPWAIT = 3'd1,
    PH_PARAM  = 3'd2,
    PH_PWAIT  = 3'd3,
    PH_EXEC   = 3'd4,
    PH_RESULT = 3'd5
  } phase_t;

  localparam logic [7:0] BAD_OPCODE_STATUS = 8'h80;

  // Returns {known, length}
  function automatic logic [LEN_W:0] op_lookup(input logic [4:0] code);
    logic [LEN_W:0] r;
    case (code)
      5'h03:   r = {1'b1, LEN_W'(2)};
      5'h04:   r = {1'b1, LEN_W'(1)};
      5'h05:   r = {1'b1, LEN_W'(8)};
      5'h06:   r = {1'b1, LEN_W'(8)};
      5'h07:   r = {1'b1, LEN_W'(1)};
      5'h08:   r = {1'b1, LEN_W'(0)};
      5'h0A:   r = {1'b1, LEN_W'(1)};
      5'h0D:   r = {1'b1, LEN_W'(5)};
      5'h0F:   r = {1'b1, LEN_W'(2)};
      5'h13:   r = {1'b1, LEN_W'(3)};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dcmd_len_lut.sv
module dcmd_len_lut
  import dcmd_pkg::*;
(
  input  logic [4:0]       code_i,
  output logic             known_o,
  output logic [LEN_W-1:0] len_o
);

  always_comb begin
    {known_o, len_o} = op_lookup(code_i);
  end

endmodule

// File: rtl/dcmd_param_store.sv
module dcmd_param_store #(
  parameter int SLOTS  = 8,
  parameter int BYTE_W = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [BYTE_W-1:0]       data_i,
  output logic [SLOTS*BYTE_W-1:0] flat_o
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = we_i && (idx_i == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= data_i;
    end

    assign flat_o[s*BYTE_W +: BYTE_W] = slot_q;
  end

endmodule

// File: rtl/dcmd_fsm.sv
module dcmd_fsm
  import dcmd_pkg::*;
#(
  parameter int SLOTS  = MAX_PARAMS,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             byte_done,
  input  logic             rd_stb,
  input  logic             exec_done,
  input  logic             op_known,
  input  logic [LEN_W-1:0] op_len,
  output logic             capture_op,
  output logic             param_we,
  output logic [IDX_W-1:0] param_idx,
  output logic             ready,
  output logic             dir,
  output logic             fifo_block,
  output logic             invalid,
  output logic             overrun,
  output logic             cmd_valid
);

  phase_t           ph_q, ph_d;
  logic [LEN_W-1:0] rx_q, rx_d;
  logic             ovr_q, ovr_d;
  logic             cv_q, cv_d;
  logic             accept;

  // Handshake bits are decoded from the state register only
  always_comb begin
    ready = (ph_q == PH_IDLE) || (ph_q == PH_PARAM) || (ph_q == PH_RESULT);
    dir   = (ph_q == PH_RESULT);
  end

  assign accept     = wr_stb && ready && !dir;
  assign capture_op = accept && (ph_q == PH_IDLE);
  assign param_we   = accept && (ph_q == PH_PARAM);
  assign param_idx  = IDX_W'(rx_q);

  always_comb begin
    ph_d  = ph_q;
    rx_d  = rx_q;
    cv_d  = 1'b0;
    ovr_d = ovr_q | (wr_stb && !accept);
    case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d = PH_OPWAIT;
          rx_d = '0;
        end
      end
      PH_OPWAIT: begin
        if (byte_done) begin
          if (!op_known)          ph_d = PH_RESULT;
          else if (op_len == '0) begin
            ph_d = PH_EXEC;
            cv_d = 1'b1;
          end else                ph_d = PH_PARAM;
        end
      end
      PH_PARAM: begin
        if (accept) begin
          ph_d = PH_PWAIT;
          rx_d = rx_q + LEN_W'(1);
        end
      end
      PH_PWAIT: begin
        if (byte_done) begin
          if (rx_q == op_len) begin
            ph_d = PH_EXEC;
            cv_d = 1'b1;
          end else ph_d = PH_PARAM;
        end
      end
      PH_EXEC:   if (exec_done) ph_d = PH_IDLE;
      PH_RESULT: if (rd_stb)    ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      rx_q  <= '0;
      ovr_q <= 1'b0;
      cv_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      rx_q  <= rx_d;
      ovr_q <= ovr_d;
      cv_q  <= cv_d;
    end
  end

  assign fifo_block = (ph_q != PH_EXEC);
  assign invalid    = (ph_q == PH_RESULT);
  assign overrun    = ovr_q;
  assign cmd_valid  = cv_q;

endmodule

// File: rtl/disk_cmd_intake.sv
module disk_cmd_intake
  import dcmd_pkg::*;
#(
  parameter int SLOTS  = MAX_PARAMS,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    byte_done,
  input  logic                    rd_stb,
  input  logic                    exec_done,
  output logic                    ready_o,
  output logic                    dir_o,
  output logic                    fifo_block_o,
  output logic                    overrun_o,
  output logic                    invalid_o,
  output logic [BYTE_W-1:0]       result_o,
  output logic                    cmd_valid_o,
  output logic [BYTE_W-1:0]       cmd_op_o,
  output logic [LEN_W-1:0]        param_count_o,
  output logic [SLOTS*BYTE_W-1:0] params_o
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [BYTE_W-1:0] op_q;
  logic              op_known;
  logic [LEN_W-1:0]  op_len;
  logic              capture_op;
  logic              param_we;
  logic [IDX_W-1:0]  param_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          op_q <= '0;
    else if (capture_op) op_q <= wr_data;
  end

  dcmd_len_lut i_lut (
    .code_i  (op_q[4:0]),
    .known_o (op_known),
    .len_o   (op_len)
  );

  dcmd_fsm #(.SLOTS(SLOTS)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .byte_done  (byte_done),
    .rd_stb     (rd_stb),
    .exec_done  (exec_done),
    .op_known   (op_known),
    .op_len     (op_len),
    .capture_op (capture_op),
    .param_we   (param_we),
    .param_idx  (param_idx),
    .ready      (ready_o),
    .dir        (dir_o),
    .fifo_block (fifo_block_o),
    .invalid    (invalid_o),
    .overrun    (overrun_o),
    .cmd_valid  (cmd_valid_o)
  );

  dcmd_param_store #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (param_we),
    .idx_i  (param_idx),
    .data_i (wr_data),
    .flat_o (params_o)
  );

  assign cmd_op_o      = op_q;
  assign param_count_o = op_len;
  assign result_o      = invalid_o ? BYTE_W'(BAD_OPCODE_STATUS) : '0;

endmodule

// File: rtl/dcmd_checker.sv
module dcmd_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic byte_done,
  input logic rd_stb,
  input logic exec_done,
  input logic ready_o,
  input logic dir_o,
  input logic fifo_block_o,
  input logic overrun_o,
  input logic invalid_o,
  input logic cmd_valid_o
);

  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ready_o && !dir_o) |=> !ready_o);

  a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !byte_done && !exec_done && !cmd_valid_o) |=> !ready_o);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  a_r5_busy_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (!ready_o && !fifo_block_o));

  a_r6_fifo_off_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> fifo_block_o);

  a_r8_invalid_offers_byte: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (ready_o && dir_o));

  a_r8_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_o && rd_stb) |=> (!invalid_o && ready_o && !dir_o));

  a_r10_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !(ready_o && !dir_o)) |=> overrun_o);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

endmodule

bind disk_cmd_intake dcmd_checker i_dcmd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_stb       (wr_stb),
  .byte_done    (byte_done),
  .rd_stb       (rd_stb),
  .exec_done    (exec_done),
  .ready_o      (ready_o),
  .dir_o        (dir_o),
  .fifo_block_o (fifo_block_o),
  .overrun_o    (overrun_o),
  .invalid_o    (invalid_o),
  .cmd_valid_o  (cmd_valid_o)
);

// File: tb/test_disk_cmd_intake.sv
`timescale 1ns/1ps
module test_disk_cmd_intake;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        byte_done = 1'b0;
  logic        rd_stb = 1'b0;
  logic        exec_done = 1'b0;
  logic        ready_o, dir_o, fifo_block_o, overrun_o, invalid_o, cmd_valid_o;
  logic [7:0]  result_o, cmd_op_o;
  logic [3:0]  param_count_o;
  logic [63:0] params_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  disk_cmd_intake i_disk_cmd_intake (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .byte_done(byte_done), .rd_stb(rd_stb), .exec_done(exec_done),
    .ready_o(ready_o), .dir_o(dir_o), .fifo_block_o(fifo_block_o),
    .overrun_o(overrun_o), .invalid_o(invalid_o), .result_o(result_o),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .param_count_o(param_count_o), .params_o(params_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] b);
    @(negedge clk); wr_data = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic processed;
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0;
  endtask

  task automatic finish_exec;
    @(negedge clk); exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
  endtask

  // Sends a valid command; checks handshake per byte and the final pulse
  task automatic run_cmd(input logic [7:0] op, input int n, input logic [7:0] seed);
    host_write(op);
    chk("R3", "ready after opcode", 64'(ready_o), 64'd0);
    processed();
    if (n == 0) begin
      chk("R5", "valid pulse (no params)", 64'(cmd_valid_o), 64'd1);
    end else begin
      chk("R4", "ready for param", 64'({ready_o, dir_o}), 64'b10);
      for (int k = 0; k < n; k++) begin
        host_write(seed + 8'(k * 17));
        chk("R3", "ready after param", 64'(ready_o), 64'd0);
        processed();
        if (k < n - 1) chk("R4", "next param request", 64'({ready_o, dir_o, cmd_valid_o}), 64'b100);
      end
      chk("R5", "valid pulse", 64'(cmd_valid_o), 64'd1);
    end
    chk("R6", "fifo enabled in exec", 64'(fifo_block_o), 64'd0);
    chk("R9", "length", 64'(param_count_o), 64'(n));
    chk("R7", "opcode held", 64'(cmd_op_o), 64'(op));
    for (int k = 0; k < n; k++)
      chk("R7", "param byte", 64'(params_o[8*k +: 8]), 64'(seed + 8'(k * 17)));
    @(negedge clk);
    chk("R5", "pulse ends", 64'(cmd_valid_o), 64'd0);
    chk("R5", "busy until exec_done", 64'(ready_o), 64'd0);
    finish_exec();
    chk("R5", "back to idle", 64'({ready_o, dir_o, fifo_block_o}), 64'b101);
  endtask

  task automatic t_reset;
    chk("R1", "reset handshake", 64'({ready_o, dir_o, fifo_block_o}), 64'b101);
    chk("R1", "reset flags", 64'({overrun_o, invalid_o, cmd_valid_o}), 64'b000);
  endtask

  task automatic t_invalid;
    host_write(8'h1F);
    processed();
    chk("R8", "invalid state", 64'({invalid_o, ready_o, dir_o}), 64'b111);
    chk("R8", "status byte", 64'(result_o), 64'h80);
    chk("R6", "fifo off in result", 64'(fifo_block_o), 64'd1);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R8", "after read", 64'({invalid_o, ready_o, dir_o}), 64'b010);
    chk("R10", "no overrun yet", 64'(overrun_o), 64'd0);
  endtask

  task automatic t_overrun;
    host_write(8'h07);
    host_write(8'h99);   // arrives while ready is low
    chk("R10", "overrun set", 64'(overrun_o), 64'd1);
    chk("R2", "state unchanged", 64'(ready_o), 64'd0);
    processed();
    host_write(8'h3C);
    processed();
    chk("R10", "ignored byte not stored", 64'(params_o[7:0]), 64'h3C);
    chk("R5", "command completes", 64'(cmd_valid_o), 64'd1);
    finish_exec();
    chk("R10", "overrun sticky", 64'(overrun_o), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cmd(8'h03, 2, 8'hA0);   // R9 5'h03 -> 2
    run_cmd(8'h08, 0, 8'h00);   // R9 5'h08 -> 0
    t_invalid();
    run_cmd(8'h06, 8, 8'h11);   // R9 5'h06 -> 8
    run_cmd(8'h4D, 5, 8'h30);   // R9 upper bits ignored, 5'h0D -> 5
    t_overrun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule